// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block is a small trigger sequencer for on-chip debug. Once armed, it walks through a short chain of states (Stage One, Stage Two, Stage Three and Final) as match events arrive from four comparator channels. A match counts only when the enable bit for its channel is set. When the sequencer reaches Final, it raises a one-cycle trigger pulse and a final flag that stays high.

A 4-bit selection code decides what happens in Stage One. For each enabled match channel, the code gives a target: Stage Two, Stage Three, Final, or nothing. Two rules settle the case where several matches arrive in one cycle. A match that targets Final always wins. Otherwise the lowest channel number wins.

From Stage Two or Stage Three, any enabled match moves the sequencer to Final. The selection code sits behind a simple write port, and writes are accepted only while the sequencer is not armed. Dropping the arm input returns the sequencer to idle from any state.

Top module: `trig_seq_top`

## Requirements
- R1: After a synchronous active-low reset, the outputs hold the following values: `cfg_rd_data` = 0000, `state_out` = 0 (idle), `trig_pulse` = 0 and `final_flag` = 0.
- R2: While `arm` is low, a write with `cfg_wr_en` high loads `cfg_wr_data` into the selection code. `cfg_rd_data` shows the new value from the cycle after the write edge, and it always reflects the current code.
- R3: A write made while `arm` is high is ignored, and `cfg_rd_data` keeps its previous value.
- R4: The state encoding on `state_out` is 0 idle, 1 Stage One, 2 Stage Two, 3 Stage Three and 4 Final. If `arm` is high in a cycle and was low in the previous cycle (reset counts as low), an idle sequencer moves to Stage One at the next edge. If `arm` is low, the sequencer returns to idle at the next edge from any state.
- R5: In Stage One, each enabled match channel has a target set by the code. Channels are numbered 0 to 3. The codes are:
  - 0001: ch0 to Stage Two, ch1 to Stage Three.
  - 0010: ch0 to Stage Two, ch2 to Stage Three.
  - 0011: ch1 to Stage Two, ch3 to Stage Three.
  - 0100: every channel to Stage Two.
  - 0101: every channel to Stage Three.
  - 0110: every channel to Final.
  - 0111: ch2 to Stage Two.
  - 1000: ch2 to Stage Three.
  - 1001: ch2 to Final.
  - 1010: ch3 to Stage Three, ch1 to Final.
  - 1011: ch1 to Stage Three, ch0 to Final.
  - 1100: ch2 to Stage Three, ch0 to Final.
  - 1101: ch0, ch1 and ch2 to Stage Two.
  - 0000, 1110 and 1111: no channel has a target.

  Any channel without a target has no effect, and the sequencer stays in Stage One.
- R6: When several enabled matches arrive in Stage One in the same cycle, a match whose target is Final wins over all others. Otherwise the lowest-numbered channel that has a target wins.
- R7: `match_in[i]` is an event only when `cmp_en[i]` is 1. A match on a disabled channel has no effect in any state.
- R8: In Stage Two or Stage Three, any enabled match moves the sequencer to Final at the next edge. With no enabled match, the state holds.
- R9: `trig_pulse` is high for exactly the first cycle in which `state_out` is 4. `final_flag` is high in every cycle spent in Final and clears when the sequencer is disarmed. Final is held until `arm` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | Arms the sequencer; low returns it to idle |
| cfg_wr_en | input | 1 | Write strobe for the selection code |
| cfg_wr_data | input | 4 | Selection code to write |
| cfg_rd_data | output | 4 | Current selection code |
| cmp_en | input | 4 | Per-channel comparator enable |
| match_in | input | 4 | Per-channel match events |
| state_out | output | 3 | Current sequencer state (encoding in R4) |
| trig_pulse | output | 1 | One-cycle pulse on entry to Final |
| final_flag | output | 1 | High while in Final |

## Verification
The assertions assume that `arm`, `cfg_wr_en`, `cmp_en` and `match_in` are stable, known values at each rising edge, and that reset is applied before arming. The bench drives every input on the falling edge from one task, so values never change near the sampling edge. It keeps `arm` mostly high, with short low spells, so that both the rearm path and the disarm path are exercised.

Match vectors are drawn with a bias toward sparse and simultaneous patterns, and the enable mask is randomised separately. This produces matches on disabled channels inside the valid input space.

// File: rtl/trig_seq_pkg.sv
// Package: shared types and the Stage One channel-target table.
// Assumes a channel count of at most 4 for the fixed mapping; extra
// channels get no target.
package trig_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ONE   = 3'd1,
        ST_TWO   = 3'd2,
        ST_THREE = 3'd3,
        ST_FIN   = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_TWO   = 2'd1,
        TGT_THREE = 2'd2,
        TGT_FIN   = 2'd3
    } seq_tgt_e;

    // Target of channel ch in Stage One under selection code sel.
    function automatic seq_tgt_e chan_target(input logic [3:0] sel, input int ch);
        seq_tgt_e t;
        t = TGT_NONE;
        unique case (sel)
            4'h1: begin
                if (ch == 0) t = TGT_TWO;
                if (ch == 1) t = TGT_THREE;
            end
            4'h2: begin
                if (ch == 0) t = TGT_TWO;
                if (ch == 2) t = TGT_THREE;
            end
            4'h3: begin
                if (ch == 1) t = TGT_TWO;
                if (ch == 3) t = TGT_THREE;
            end
            4'h4: if (ch < 4) t = TGT_TWO;
            4'h5: if (ch < 4) t = TGT_THREE;
            4'h6: if (ch < 4) t = TGT_FIN;
            4'h7: if (ch == 2) t = TGT_TWO;
            4'h8: if (ch == 2) t = TGT_THREE;
            4'h9: if (ch == 2) t = TGT_FIN;
            4'hA: begin
                if (ch == 3) t = TGT_THREE;
                if (ch == 1) t = TGT_FIN;
            end
            4'hB: begin
                if (ch == 1) t = TGT_THREE;
                if (ch == 0) t = TGT_FIN;
            end
            4'hC: begin
                if (ch == 2) t = TGT_THREE;
                if (ch == 0) t = TGT_FIN;
            end
            4'hD: if (ch < 3) t = TGT_TWO;
            default: t = TGT_NONE;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/seq_ctrl_reg.sv
// Module: holds the selection code.
// Writes land only while the sequencer is disarmed. The read port shows
// the stored code at all times. Assumes arm is a clean level.
module seq_ctrl_reg #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_data,
    output logic [CODE_W-1:0] code
);

    // Load the code on a write while disarmed; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= '0;
        end else if (wr_en && !arm) begin
            code <= wr_data;
        end
    end

    // R3
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (code == $past(code)));

    // R2
    cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !arm) |=> (code == $past(wr_data)));

endmodule

// File: rtl/seq_match_gate.sv
// Module: qualifies raw match events with the per-channel comparator
// enables. Assumes both vectors are sampled in the same cycle.
module seq_match_gate #(
    parameter int NUM_CH = 4
) (
    input  logic [NUM_CH-1:0] match_in,
    input  logic [NUM_CH-1:0] cmp_en,
    output logic [NUM_CH-1:0] ev,
    output logic              any_ev
);

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_gate
            // A channel fires only when its comparator is enabled.
            assign ev[g] = match_in[g] & cmp_en[g];
        end
    endgenerate

    // Collapse the channel events for the later stages.
    assign any_ev = |ev;

endmodule

// File: rtl/seq_s1_decode.sv
// Module: Stage One next-state resolution.
// Maps each enabled event to a target under the selection code, then
// picks one winner: any Final-target event first, otherwise the lowest
// channel with a target. Purely combinational.
module seq_s1_decode
    import trig_seq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CODE_W = 4
) (
    input  logic [CODE_W-1:0] code,
    input  logic [NUM_CH-1:0] ev,
    output seq_tgt_e          next_tgt,
    output logic              fin_req,
    output logic [NUM_CH-1:0] grant
);

    seq_tgt_e          ch_tgt [NUM_CH];
    logic [NUM_CH-1:0] fin_vec;
    logic [NUM_CH-1:0] live_vec;

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_map
            // Target of this channel when it fires, else none.
            assign ch_tgt[g]   = ev[g] ? chan_target(code[3:0], g) : TGT_NONE;
            assign fin_vec[g]  = (ch_tgt[g] == TGT_FIN);
            assign live_vec[g] = (ch_tgt[g] != TGT_NONE);
        end
    endgenerate

    assign fin_req = |fin_vec;

    // Priority pick: Final-target events first, then lowest live channel.
    always_comb begin
        logic found;
        grant = '0;
        found = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (!found && ((fin_req && fin_vec[i]) || (!fin_req && live_vec[i]))) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    // Target of the winning channel.
    always_comb begin
        next_tgt = TGT_NONE;
        for (int i = 0; i < NUM_CH; i++) begin
            if (grant[i]) next_tgt = ch_tgt[i];
        end
    end

endmodule

// File: rtl/trig_seq_top.sv
// Module: debug trigger state sequencer top.
// Holds the state register, arm edge detect, trigger pulse and final
// flag. Assumes inputs are synchronous to clk; reset is synchronous,
// active low.
module trig_seq_top
    import trig_seq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              cfg_wr_en,
    input  logic [CODE_W-1:0] cfg_wr_data,
    output logic [CODE_W-1:0] cfg_rd_data,
    input  logic [NUM_CH-1:0] cmp_en,
    input  logic [NUM_CH-1:0] match_in,
    output logic [2:0]        state_out,
    output logic              trig_pulse,
    output logic              final_flag
);

    seq_state_e        state_q, state_d;
    logic              arm_q;
    logic [CODE_W-1:0] code;
    logic [NUM_CH-1:0] ev;
    logic              any_ev;
    seq_tgt_e          s1_tgt;
    logic              s1_fin_req;
    logic [NUM_CH-1:0] s1_grant;
    logic              trig_q, flag_q;

    seq_ctrl_reg #(.CODE_W(CODE_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .code    (code)
    );

    seq_match_gate #(.NUM_CH(NUM_CH)) u_gate (
        .match_in (match_in),
        .cmp_en   (cmp_en),
        .ev       (ev),
        .any_ev   (any_ev)
    );

    seq_s1_decode #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_dec (
        .code     (code),
        .ev       (ev),
        .next_tgt (s1_tgt),
        .fin_req  (s1_fin_req),
        .grant    (s1_grant)
    );

    // Next-state selection; disarm overrides every state.
    always_comb begin
        state_d = state_q;
        if (!arm) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (!arm_q) state_d = ST_ONE;
                ST_ONE: begin
                    unique case (s1_tgt)
                        TGT_TWO:   state_d = ST_TWO;
                        TGT_THREE: state_d = ST_THREE;
                        TGT_FIN:   state_d = ST_FIN;
                        default:   state_d = ST_ONE;
                    endcase
                end
                ST_TWO, ST_THREE: if (any_ev) state_d = ST_FIN;
                ST_FIN:   state_d = ST_FIN;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // State, arm history, pulse and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            arm_q   <= 1'b0;
            trig_q  <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            arm_q   <= arm;
            trig_q  <= (state_d == ST_FIN) && (state_q != ST_FIN);
            flag_q  <= (state_d == ST_FIN);
        end
    end

    assign state_out   = state_q;
    assign cfg_rd_data = code;
    assign trig_pulse  = trig_q;
    assign final_flag  = flag_q;

    // R4
    disarm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> (state_out == 3'd0) && !final_flag);

    // R6
    fin_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ONE && arm && s1_fin_req) |=> (state_out == 3'd4));

    // R6
    grant_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s1_grant));

    // R8
    mid_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_TWO || state_q == ST_THREE) && arm && |(match_in & cmp_en))
        |=> (state_out == 3'd4));

    // R9
    pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |=> !trig_pulse);

    // R9
    pulse_in_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> (state_out == 3'd4) && final_flag);

    // R7
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TWO && arm && (match_in & cmp_en) == '0) |=> (state_out == 3'd2));

endmodule

// File: tb/trig_seq_top_tb.sv
module trig_seq_top_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       arm;
    logic       cfg_wr_en;
    logic [3:0] cfg_wr_data;
    logic [3:0] cfg_rd_data;
    logic [3:0] cmp_en;
    logic [3:0] match_in;
    logic [2:0] state_out;
    logic       trig_pulse;
    logic       final_flag;

    int checks   = 0;
    int failures = 0;

    // model state
    int   m_state = 0;
    logic m_arm_q = 1'b0;
    logic [3:0] m_code = 4'h0;
    logic m_trig = 1'b0;
    logic m_flag = 1'b0;
    string st_tag = "R1";
    string cfg_tag = "R1";

    always #2.5 clk = ~clk;

    trig_seq_top u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm         (arm),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_data (cfg_wr_data),
        .cfg_rd_data (cfg_rd_data),
        .cmp_en      (cmp_en),
        .match_in    (match_in),
        .state_out   (state_out),
        .trig_pulse  (trig_pulse),
        .final_flag  (final_flag)
    );

    // Stage One target from the requirement table: 0 none, 2, 3, 4 = Final.
    function automatic int m_target(input logic [3:0] c, input int ch);
        if (c == 4'h4) return 2;
        if (c == 4'h5) return 3;
        if (c == 4'h6) return 4;
        if (c == 4'hD) return (ch <= 2) ? 2 : 0;
        if (c == 4'h1) return (ch == 0) ? 2 : (ch == 1) ? 3 : 0;
        if (c == 4'h2) return (ch == 0) ? 2 : (ch == 2) ? 3 : 0;
        if (c == 4'h3) return (ch == 1) ? 2 : (ch == 3) ? 3 : 0;
        if (c == 4'h7) return (ch == 2) ? 2 : 0;
        if (c == 4'h8) return (ch == 2) ? 3 : 0;
        if (c == 4'h9) return (ch == 2) ? 4 : 0;
        if (c == 4'hA) return (ch == 1) ? 4 : (ch == 3) ? 3 : 0;
        if (c == 4'hB) return (ch == 0) ? 4 : (ch == 1) ? 3 : 0;
        if (c == 4'hC) return (ch == 0) ? 4 : (ch == 2) ? 3 : 0;
        return 0;
    endfunction

    // Stage One resolution: Final first, else lowest channel with a target.
    function automatic int m_s1_next(input logic [3:0] c, input logic [3:0] evs);
        for (int i = 0; i < 4; i++)
            if (evs[i] && m_target(c, i) == 4) return 4;
        for (int i = 0; i < 4; i++)
            if (evs[i] && m_target(c, i) != 0) return m_target(c, i);
        return 1;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Compare outputs, then drive one cycle of inputs and advance the model.
    task automatic step(input logic r, input logic a, input logic we, input logic [3:0] wd,
                        input logic [3:0] en, input logic [3:0] m);
        int   nxt;
        logic [3:0] evs;
        @(negedge clk);
        chk(st_tag, "state_out", int'(state_out), m_state);
        chk(cfg_tag, "cfg_rd_data", int'(cfg_rd_data), int'(m_code));
        chk((st_tag == "R1") ? "R1" : "R9", "trig_pulse", int'(trig_pulse), int'(m_trig));
        chk((st_tag == "R1") ? "R1" : "R9", "final_flag", int'(final_flag), int'(m_flag));
        rst_n = r; arm = a; cfg_wr_en = we; cfg_wr_data = wd; cmp_en = en; match_in = m;
        evs = m & en;
        if (!r) begin
            m_state = 0; m_arm_q = 0; m_code = 0; m_trig = 0; m_flag = 0;
            st_tag = "R1"; cfg_tag = "R1";
        end else begin
            cfg_tag = (we && a) ? "R3" : "R2";
            if (we && !a) m_code = wd;
            if (!a) begin
                nxt = 0; st_tag = "R4";
            end else if (m_state == 0) begin
                nxt = m_arm_q ? 0 : 1; st_tag = "R4";
            end else if (m_state == 1) begin
                nxt = m_s1_next(m_code, evs);
                st_tag = ((m & ~en) != 0) ? "R7" : ($countones(evs) > 1) ? "R6" : "R5";
            end else if (m_state == 2 || m_state == 3) begin
                nxt = (evs != 0) ? 4 : m_state;
                st_tag = ((m & ~en) != 0) ? "R7" : "R8";
            end else begin
                nxt = 4; st_tag = "R9";
            end
            m_trig = (nxt == 4) && (m_state != 4);
            m_flag = (nxt == 4);
            m_state = nxt;
            m_arm_q = a;
        end
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 0; arm = 0; cfg_wr_en = 0; cfg_wr_data = 0; cmp_en = 0; match_in = 0;
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        // R1 reset state observed on next step
        step(1, 0, 0, 0, 0, 0);
        // R2 write code 0xB while disarmed
        step(1, 0, 1, 4'hB, 4'hF, 0);
        // R4 arm, then R6: ch0->Final beats ch1->Stage Three
        step(1, 1, 0, 0, 4'hF, 0);
        step(1, 1, 1, 4'h3, 4'hF, 4'b0011); // R3 write while armed ignored
        step(1, 1, 0, 0, 4'hF, 0);
        step(1, 1, 0, 0, 4'hF, 0);          // R9 stays in Final
        step(1, 0, 0, 0, 4'hF, 0);          // R4 disarm
        // R6 lowest channel wins with code 0x1: ch0 and ch1 both fire -> Stage Two
        step(1, 0, 1, 4'h1, 4'hF, 0);
        step(1, 1, 0, 0, 4'hF, 0);
        step(1, 1, 0, 0, 4'hF, 4'b0011);
        step(1, 1, 0, 0, 4'h0, 4'hF);        // R7 disabled channels ignored in Stage Two
        step(1, 1, 0, 0, 4'h8, 4'h8);        // R8 enabled match -> Final
        step(1, 1, 0, 0, 4'h0, 0);
        step(1, 0, 0, 0, 0, 0);
        // R5 reserved code has no effect
        step(1, 0, 1, 4'hE, 4'hF, 0);
        step(1, 1, 0, 0, 4'hF, 0);
        step(1, 1, 0, 0, 4'hF, 4'hF);
        step(1, 1, 0, 0, 4'hF, 4'hF);
        step(1, 0, 0, 0, 0, 0);
        // R7 masked Final-target match in Stage One (code 0x9, ch2 disabled)
        step(1, 0, 1, 4'h9, 0, 0);
        step(1, 1, 0, 0, 4'hB, 4'h4);
        step(1, 1, 0, 0, 4'hB, 4'h4);
        step(1, 1, 0, 0, 4'h4, 4'h4);
        step(1, 1, 0, 0, 0, 0);
        // random phase
        for (int n = 0; n < 4000; n++) begin
            logic a, we;
            logic [3:0] wd, en, m;
            a  = ($urandom_range(0, 15) != 0);
            we = ($urandom_range(0, 3) == 0);
            wd = 4'($urandom_range(0, 15));
            en = 4'($urandom_range(0, 15));
            m  = ($urandom_range(0, 2) == 0) ? 4'($urandom_range(0, 15))
                                             : (4'b1 << $urandom_range(0, 3)) & {4{$urandom_range(0, 1) == 1}};
            step(($urandom_range(0, 499) != 0), a, we, wd, en, m);
        end
        step(1, 0, 0, 0, 0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule